// File: doc/BRIEF.md
# Three-Phase Output Emergency Cutoff

This block sits between a three-phase PWM generator and the six inverter pins (high and low side for each of the phases U, V and W). In normal operation it passes the six drive levels through with every pin enabled. A hardware fault line, active low, can shut all six pins off at once. Shutting a pin off means releasing it to high impedance by dropping its output enable. A solid drive level is never forced.

A small control register decides whether the fault line is allowed to act. The same register also holds a reload-timing select that is passed on to the PWM timer. A separate protect register guards the control register: software must arm the protect bit first, and that arming is good for one control write only. Once a cutoff has happened it is latched. It stays latched until the fault line is high again and software has cleared the enable bit.

Top module: `phase_trip_gate`

## Requirements
- R1: After reset the enable bit, the reload select and the protect bit are 0, `tripped` is 0, every `pad_oe` bit is 1 and `pad_out` follows `drv_in`.
- R2: While the enable bit (control bit 1) is 0, a low level on `fault_n` of any length changes neither `pad_oe` nor `tripped`.
- R3: While the enable bit is 1, a low level on `fault_n` drives all six `pad_oe` bits to 0 on the third rising clock edge after the level is applied (two synchronizer stages, then the latch). `pad_oe` stays 0 whatever `drv_in` does.
- R4: A latched cutoff holds while the enable bit stays 1, even after `fault_n` returns high. It also holds while the synchronized fault is still low, even after the enable bit has been cleared.
- R5: The cutoff is released on the first clock edge at which the synchronized fault is high and the enable bit is 0 together. `pad_oe` then returns to all ones.
- R6: A write to the control register (`reg_sel`=0) while the protect bit is 0 leaves the register unchanged. The protect bit is bit 0 of the register at `reg_sel`=1.
- R7: An accepted control write clears the protect bit. A second control write without re-arming is ignored.
- R8: Reading the control register returns the reload select in bit 0 and the enable bit in bit 1. Bits 7:2 read as zero whatever was written.
- R9: `reload_sel` follows the stored reload select (0 = reload on timer underflow, 1 = reload on odd auxiliary timer events). It is forced to 0 while `mode_simple` or `mode_saw` is high.
- R10: `tripped` is high exactly while the cutoff is latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 control, 1 protect |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| fault_n | input | 1 | Asynchronous fault input, active low |
| mode_simple | input | 1 | Simple three-phase mode is active |
| mode_saw | input | 1 | Sawtooth modulation mode is active |
| drv_in | input | 6 | Drive levels from the PWM generator (U, U-bar, V, V-bar, W, W-bar) |
| pad_out | output | 6 | Pin output levels |
| pad_oe | output | 6 | Pin output enables, 0 = high impedance |
| reload_sel | output | 1 | Effective reload-timing select for the timer |
| tripped | output | 1 | Cutoff latch state |

## Verification
The release path has two inputs: the synchronized fault returning high, and a software write that clears the enable bit. Both can land on the same clock edge. The bench times a control write so that it completes on exactly the edge at which the second synchronizer stage sees the fault line high again. It then checks that `tripped` is still set just after that edge and clears on the following one. A second case clears the enable bit while the fault is still low. There the latch must hold until the synchronized fault rises, and only then release.

// File: rtl/phase_trip_pkg.sv
package phase_trip_pkg;
  localparam int REG_W      = 8;
  localparam int BIT_RELOAD = 0;
  localparam int BIT_ENABLE = 1;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_PROT = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic enable;
    logic reload;
  } ctrl_t;

  // Readback image of the control register: upper bits are always zero.
  function automatic logic [REG_W-1:0] ctrl_image(ctrl_t c);
    logic [REG_W-1:0] img;
    img             = '0;
    img[BIT_RELOAD] = c.reload;
    img[BIT_ENABLE] = c.enable;
    return img;
  endfunction

  // Next state of the cutoff latch.
  function automatic logic trip_next(logic q, logic en, logic fault_low);
    logic set_c;
    logic clr_c;
    set_c = en & fault_low;
    clr_c = ~en & ~fault_low;
    return set_c | (q & ~clr_c);
  endfunction

  // Reload select as seen by the timer.
  function automatic logic reload_eff(logic stored, logic simple_m, logic saw_m);
    return stored & ~(simple_m | saw_m);
  endfunction
endpackage

// File: rtl/pt_sync.sv
module pt_sync #(
  parameter int   STAGES   = 2,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pt_regs.sv
module pt_regs
  import phase_trip_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             mode_simple,
  input  logic             mode_saw,
  output ctrl_t            ctrl_q,
  output logic             protect_q,
  output logic [REG_W-1:0] rd_data,
  output logic             reload_sel,
  output logic             ctrl_wr_ok,
  output logic             ctrl_wr_blocked
);
  logic ctrl_wr;
  logic prot_wr;

  assign ctrl_wr         = wr_en & (reg_sel == SEL_CTRL);
  assign prot_wr         = wr_en & (reg_sel == SEL_PROT);
  assign ctrl_wr_ok      = ctrl_wr & protect_q;
  assign ctrl_wr_blocked = ctrl_wr & ~protect_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr_ok) begin
      ctrl_q.reload <= wr_data[BIT_RELOAD];
      ctrl_q.enable <= wr_data[BIT_ENABLE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          protect_q <= 1'b0;
    else if (prot_wr)    protect_q <= wr_data[0];
    else if (ctrl_wr_ok) protect_q <= 1'b0;
  end

  always_comb begin
    if (reg_sel == SEL_CTRL) begin
      rd_data = ctrl_image(ctrl_q);
    end else begin
      rd_data    = '0;
      rd_data[0] = protect_q;
    end
  end

  assign reload_sel = reload_eff(ctrl_q.reload, mode_simple, mode_saw);
endmodule

// File: rtl/pt_trip.sv
module pt_trip
  import phase_trip_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic fault_low,
  output logic tripped,
  output logic trip_set,
  output logic trip_clr
);
  logic nxt;

  assign nxt      = trip_next(tripped, enable, fault_low);
  assign trip_set = ~tripped & nxt;
  assign trip_clr = tripped & ~nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tripped <= 1'b0;
    else        tripped <= nxt;
  end
endmodule

// File: rtl/pt_gate.sv
module pt_gate #(
  parameter int PINS = 6
) (
  input  logic            cut,
  input  logic [PINS-1:0] drv_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign pad_oe[i]  = ~cut;
    assign pad_out[i] = drv_in[i] & ~cut;
  end
endmodule

// File: rtl/phase_trip_gate.sv
module phase_trip_gate
  import phase_trip_pkg::*;
#(
  parameter int NUM_PHASE   = 3,
  parameter int SYNC_STAGES = 2,
  localparam int PINS       = 2 * NUM_PHASE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             fault_n,
  input  logic             mode_simple,
  input  logic             mode_saw,
  input  logic [PINS-1:0]  drv_in,
  output logic [PINS-1:0]  pad_out,
  output logic [PINS-1:0]  pad_oe,
  output logic             reload_sel,
  output logic             tripped
);
  ctrl_t ctrl_q;
  logic  protect_q;
  logic  fault_sync;
  logic  fault_low;
  logic  ctrl_wr_ok;
  logic  ctrl_wr_blocked;
  logic  trip_set;
  logic  trip_clr;

  pt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(fault_n), .q(fault_sync)
  );
  assign fault_low = ~fault_sync;

  pt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .mode_simple(mode_simple), .mode_saw(mode_saw),
    .ctrl_q(ctrl_q), .protect_q(protect_q), .rd_data(rd_data),
    .reload_sel(reload_sel), .ctrl_wr_ok(ctrl_wr_ok),
    .ctrl_wr_blocked(ctrl_wr_blocked)
  );

  pt_trip u_trip (
    .clk(clk), .rst_n(rst_n), .enable(ctrl_q.enable), .fault_low(fault_low),
    .tripped(tripped), .trip_set(trip_set), .trip_clr(trip_clr)
  );

  pt_gate #(.PINS(PINS)) u_gate (
    .cut(tripped), .drv_in(drv_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: rtl/phase_trip_chk.sv
module phase_trip_chk #(
  parameter int PINS = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      wr_bits,
  input logic            enable,
  input logic            reload,
  input logic            protect,
  input logic            fault_low,
  input logic            tripped,
  input logic [PINS-1:0] pad_oe,
  input logic            ctrl_wr_ok,
  input logic            ctrl_wr_blocked,
  input logic            trip_set,
  input logic            trip_clr
);
  p_cut_all_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |-> (pad_oe == '0));
  p_pins_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tripped |-> (pad_oe == '1));
  p_disabled_no_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !tripped) |=> !tripped);
  p_set_needs_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trip_set |-> (enable && fault_low));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && (enable || fault_low)) |=> tripped);
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && !enable && !fault_low) |=> !tripped);
  p_clr_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trip_clr |-> (!enable && !fault_low));
  p_locked_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_blocked |=> ($stable(enable) && $stable(reload)));
  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_ok |=> ((enable == $past(wr_bits[1])) && (reload == $past(wr_bits[0]))));
  p_protect_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_ok |=> !protect);
endmodule

bind phase_trip_gate phase_trip_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_bits(wr_data[1:0]), .enable(ctrl_q.enable),
  .reload(ctrl_q.reload), .protect(protect_q), .fault_low(fault_low),
  .tripped(tripped), .pad_oe(pad_oe), .ctrl_wr_ok(ctrl_wr_ok),
  .ctrl_wr_blocked(ctrl_wr_blocked), .trip_set(trip_set), .trip_clr(trip_clr)
);

// File: tb/sim_phase_trip_gate.sv
`timescale 1ns/100ps
module sim_phase_trip_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       fault_n = 1'b1;
  logic       mode_simple = 1'b0;
  logic       mode_saw = 1'b0;
  logic [5:0] drv_in = 6'b101010;
  logic [5:0] pad_out;
  logic [5:0] pad_oe;
  logic       reload_sel;
  logic       tripped;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  phase_trip_gate u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .fault_n(fault_n),
    .mode_simple(mode_simple), .mode_saw(mode_saw), .drv_in(drv_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .reload_sel(reload_sel),
    .tripped(tripped)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(logic sel, output logic [7:0] v);
    reg_sel = sel;
    #0.5;
    v = rd_data;
  endtask

  task automatic set_ctrl(logic [7:0] d);
    wr(1'b1, 8'h01);
    wr(1'b0, d);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(1'b0, v); chk("R1 ctrl", v, 8'h00);
    rd(1'b1, v); chk("R1 protect", v, 8'h00);
    chk("R1 oe", {2'b0, pad_oe}, 8'h3f);
    chk("R1 out", {2'b0, pad_out}, {2'b0, drv_in});
    chk("R1 tripped", {7'b0, tripped}, 8'h00);
  endtask

  task automatic t_protect;
    logic [7:0] v;
    wr(1'b0, 8'h03); tick(1);
    rd(1'b0, v); chk("R6 locked write", v, 8'h00);
    wr(1'b1, 8'h01);
    rd(1'b1, v); chk("R6 protect armed", v, 8'h01);
    wr(1'b0, 8'h03);
    rd(1'b0, v); chk("R6 accepted", v, 8'h03);
    rd(1'b1, v); chk("R7 protect cleared", v, 8'h00);
    wr(1'b0, 8'h00);
    rd(1'b0, v); chk("R7 second write ignored", v, 8'h03);
  endtask

  task automatic t_readback;
    logic [7:0] v;
    set_ctrl(8'hfc);
    rd(1'b0, v); chk("R8 upper zero", v, 8'h00);
    set_ctrl(8'hff);
    rd(1'b0, v); chk("R8 bit layout", v, 8'h03);
  endtask

  task automatic t_reload;
    chk("R9 follow", {7'b0, reload_sel}, 8'h01);
    mode_simple = 1'b1; #0.5;
    chk("R9 simple forced", {7'b0, reload_sel}, 8'h00);
    mode_simple = 1'b0; mode_saw = 1'b1; #0.5;
    chk("R9 saw forced", {7'b0, reload_sel}, 8'h00);
    mode_saw = 1'b0; #0.5;
    chk("R9 restore", {7'b0, reload_sel}, 8'h01);
  endtask

  task automatic t_disabled;
    set_ctrl(8'h01);
    fault_n = 1'b0;
    tick(8);
    chk("R2 oe", {2'b0, pad_oe}, 8'h3f);
    chk("R2 tripped", {7'b0, tripped}, 8'h00);
    fault_n = 1'b1;
    tick(3);
  endtask

  task automatic t_trip;
    set_ctrl(8'h02);
    fault_n = 1'b0;
    tick(2);
    chk("R3 not before third edge", {2'b0, pad_oe}, 8'h3f);
    tick(1);
    chk("R3 cut", {2'b0, pad_oe}, 8'h00);
    chk("R10 tripped", {7'b0, tripped}, 8'h01);
    drv_in = 6'b010101; tick(1);
    chk("R3 drive ignored", {2'b0, pad_oe}, 8'h00);
  endtask

  task automatic t_hold;
    fault_n = 1'b1;
    tick(5);
    chk("R4 hold enable set", {7'b0, tripped}, 8'h01);
    fault_n = 1'b0;
    tick(3);
    set_ctrl(8'h00);
    tick(3);
    chk("R4 hold fault low", {7'b0, tripped}, 8'h01);
  endtask

  task automatic t_release;
    fault_n = 1'b1;
    tick(2);
    chk("R5 not yet", {7'b0, tripped}, 8'h01);
    tick(1);
    chk("R5 released", {7'b0, tripped}, 8'h00);
    chk("R5 oe back", {2'b0, pad_oe}, 8'h3f);
  endtask

  task automatic t_same_edge;
    set_ctrl(8'h02);
    fault_n = 1'b0;
    tick(3);
    chk("R3 retrip", {7'b0, tripped}, 8'h01);
    wr(1'b1, 8'h01);
    fault_n = 1'b1;
    tick(1);
    wr(1'b0, 8'h00);
    chk("R5 same edge held", {7'b0, tripped}, 8'h01);
    tick(1);
    chk("R5 same edge released", {7'b0, tripped}, 8'h00);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_protect();
    t_readback();
    t_reload();
    t_disabled();
    t_trip();
    t_hold();
    t_release();
    t_same_edge();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule